// File: doc/BRIEF.md
# Single-to-half precision float converter

This block turns a 32-bit IEEE 754 single-precision bit pattern into a 16-bit IEEE 754 half-precision bit pattern. It rounds to nearest with ties to even. It handles finite values that are too large for half precision, values that land in the half subnormal range, signed zeros, infinities and NaNs. Each input word comes with a valid strobe. The converted word leaves a single register stage one cycle later, and its valid strobe travels beside it.

The block chooses a rounding position from the input exponent. For values at or above the smallest normal half, it keeps ten fraction bits. For smaller values, the rounding point is fixed at a weight of 2^-24. The output magnitude is the half exponent field added to the rounded significand, not concatenated with it. A rounding carry therefore moves into the exponent on its own. This covers the step from the largest subnormal up to the smallest normal, and the step from the largest finite value up to infinity. Every NaN input leaves as one quiet pattern.

Top module: `sp2hp_conv`

## Requirements
- R1: Output bit 15 equals input bit 31 for every class of input (NaN, infinity, finite, zero).
- R2: An input whose exponent field is all ones and whose fraction is nonzero produces the quiet pattern 0x7E00 on bits 14:0.
- R3: An input with exponent all ones and fraction zero produces 0x7C00 on bits 14:0.
- R4: Finite inputs of magnitude 65520 or more produce 0x7C00 on bits 14:0. An input of 65504 produces 0x7BFF, which is the largest finite result, and so does anything just below 65520.
- R5: Inputs with single exponent field 113 or more that do not overflow keep ten fraction bits, rounded to nearest with ties to even. For example, 0x3F801000 gives 0x3C00 and 0x3F803000 gives 0x3C02.
- R6: Inputs below 2^-14 are rounded at a granularity of 2^-24, with ties to even, giving a subnormal half or zero. For example, 0x33800000 gives 0x0001, 0x33000000 gives 0x0000 and 0x33C00000 gives 0x0002.
- R7: A rounding carry out of the fraction raises the exponent. For example, 0x387FF000 gives 0x0400 and 0x3FFFF000 gives 0x4000.
- R8: Positive and negative zero, and all single subnormals, produce a zero of the input's sign.
- R9: out_valid is high exactly in the cycle after a cycle with in_valid high. A synchronous reset clears out_valid and out_data.
- R10: While in_valid is low, out_data keeps its last value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Input word is present |
| in_data | input | 32 | Single-precision bit pattern |
| out_valid | output | 1 | Converted word is present |
| out_data | output | 16 | Half-precision bit pattern |

## Verification
The bench builds the block with its default parameters: an 8-bit exponent and 23-bit fraction on the input side, and a 5-bit exponent and 10-bit fraction on the output side. These values fix the exact thresholds the checks rely on, at 65504, 65520, 2^-14 and 2^-24. They also put every rounding shift, from 13 up to the clamp at 25, within reach of stimulus whose exponents are drawn around the 100 to 145 band. Directed words cover ties on both sides of even, both carry steps, the NaN and infinity encodings, and signed zeros.

// File: rtl/sp2hp_pkg.sv
package sp2hp_pkg;

  // Class of an incoming value, used to select the output pattern
  typedef enum logic [1:0] {
    NC_FINITE = 2'd0,
    NC_INF    = 2'd1,
    NC_NAN    = 2'd2
  } num_class_e;

endpackage

// File: rtl/sp2hp_decode.sv
module sp2hp_decode
  import sp2hp_pkg::*;
#(
  parameter int IN_EXP_W  = 8,
  parameter int IN_MAN_W  = 23,
  parameter int OUT_EXP_W = 5,
  parameter int OUT_MAN_W = 10,
  parameter int SH_W      = 5
) (
  input  logic [IN_EXP_W+IN_MAN_W:0] in_bits,
  output num_class_e                 cls,
  output logic                       sgn,
  output logic [IN_MAN_W:0]          sig,
  output logic [SH_W-1:0]            shift,
  output logic [OUT_EXP_W-1:0]       exp_field,
  output logic                       huge
);
  localparam int IN_BIAS    = (1 << (IN_EXP_W - 1)) - 1;
  localparam int OUT_BIAS   = (1 << (OUT_EXP_W - 1)) - 1;
  localparam int MIN_NORM_E = IN_BIAS - OUT_BIAS + 1;
  localparam int OVF_E      = IN_BIAS + OUT_BIAS + 1;
  localparam int DROP       = IN_MAN_W - OUT_MAN_W;
  localparam int SH_MAX     = IN_MAN_W + 2;

  logic [IN_EXP_W-1:0] e;
  logic [IN_MAN_W-1:0] m;

  // Right shift that places the bit of weight 2^-24 (or the last kept
  // fraction bit for normal results) at position zero.
  function automatic logic [SH_W-1:0] calc_shift(input logic [IN_EXP_W-1:0] ex);
    int ee;
    int s;
    ee = (ex == '0) ? 1 : int'(ex);
    if (ee >= MIN_NORM_E) s = DROP;
    else s = MIN_NORM_E + DROP - ee;
    if (s > SH_MAX) s = SH_MAX;
    return SH_W'(s);
  endfunction

  function automatic logic [OUT_EXP_W-1:0] calc_exp(input logic [IN_EXP_W-1:0] ex);
    int ee;
    ee = int'(ex);
    if (ee >= MIN_NORM_E && ee < OVF_E) return OUT_EXP_W'(ee - MIN_NORM_E);
    return '0;
  endfunction

  always_comb begin
    sgn       = in_bits[IN_EXP_W+IN_MAN_W];
    e         = in_bits[IN_EXP_W+IN_MAN_W-1:IN_MAN_W];
    m         = in_bits[IN_MAN_W-1:0];
    sig       = {(e != '0), m};
    shift     = calc_shift(e);
    exp_field = calc_exp(e);
    huge      = (int'(e) >= OVF_E);
    if (&e) cls = (m != '0) ? NC_NAN : NC_INF;
    else cls = NC_FINITE;
  end

endmodule

// File: rtl/sp2hp_round.sv
module sp2hp_round #(
  parameter int SIG_W = 24,
  parameter int SH_W  = 5
) (
  input  logic [SIG_W-1:0] sig,
  input  logic [SH_W-1:0]  shift,
  output logic [SIG_W:0]   rounded,
  output logic             round_up
);
  logic [SIG_W:0]   qf;
  logic [SIG_W-1:0] gmask;
  logic [SIG_W-1:0] smask;
  logic             guard;
  logic             sticky;

  always_comb begin
    qf     = {1'b0, sig} >> shift;
    gmask  = (shift == '0) ? '0 : (SIG_W'(1) << (shift - 1'b1));
    smask  = (shift == '0) ? '0 : ~({SIG_W{1'b1}} << (shift - 1'b1));
    guard  = |(sig & gmask);
    sticky = |(sig & smask);
    // nearest, ties to even
    round_up = guard && (sticky || qf[0]);
    rounded  = qf + (SIG_W + 1)'(round_up);
  end

endmodule

// File: rtl/sp2hp_pack.sv
module sp2hp_pack
  import sp2hp_pkg::*;
#(
  parameter int SIG_W     = 24,
  parameter int OUT_EXP_W = 5,
  parameter int OUT_MAN_W = 10
) (
  input  num_class_e                   cls,
  input  logic                         sgn,
  input  logic                         huge,
  input  logic [OUT_EXP_W-1:0]         exp_field,
  input  logic [SIG_W:0]               rounded,
  output logic                         ovf,
  output logic [OUT_EXP_W+OUT_MAN_W:0] half
);
  localparam int SUM_W   = SIG_W + 2;
  localparam int MAG_W   = OUT_EXP_W + OUT_MAN_W;
  localparam logic [SUM_W-1:0] INF_MAG  = SUM_W'(((1 << OUT_EXP_W) - 1) << OUT_MAN_W);
  localparam logic [MAG_W-1:0] QNAN_MAG = MAG_W'((((1 << OUT_EXP_W) - 1) << OUT_MAN_W) | (1 << (OUT_MAN_W - 1)));

  logic [SUM_W-1:0] sum;

  always_comb begin
    // exponent field added, not concatenated: a fraction carry rolls upward
    sum = (SUM_W'(exp_field) << OUT_MAN_W) + SUM_W'(rounded);
    ovf = huge || (sum >= INF_MAG);
    unique case (cls)
      NC_NAN:  half = {sgn, QNAN_MAG};
      NC_INF:  half = {sgn, INF_MAG[MAG_W-1:0]};
      default: half = ovf ? {sgn, INF_MAG[MAG_W-1:0]} : {sgn, sum[MAG_W-1:0]};
    endcase
  end

endmodule

// File: rtl/sp2hp_conv.sv
module sp2hp_conv
  import sp2hp_pkg::*;
#(
  parameter int IN_EXP_W  = 8,
  parameter int IN_MAN_W  = 23,
  parameter int OUT_EXP_W = 5,
  parameter int OUT_MAN_W = 10
) (
  input  logic                         clk,
  input  logic                         rst,
  input  logic                         in_valid,
  input  logic [IN_EXP_W+IN_MAN_W:0]   in_data,
  output logic                         out_valid,
  output logic [OUT_EXP_W+OUT_MAN_W:0] out_data
);
  localparam int IN_W  = 1 + IN_EXP_W + IN_MAN_W;
  localparam int OUT_W = 1 + OUT_EXP_W + OUT_MAN_W;
  localparam int SIG_W = IN_MAN_W + 1;
  localparam int SH_W  = $clog2(IN_MAN_W + 3);
  localparam logic [SIG_W:0] RND_MAX = (SIG_W + 1)'(1) << (OUT_MAN_W + 1);
  localparam logic [OUT_MAN_W-1:0] QNAN_FRAC = OUT_MAN_W'(1) << (OUT_MAN_W - 1);

  num_class_e             dec_cls;
  logic                   dec_sgn;
  logic [SIG_W-1:0]       dec_sig;
  logic [SH_W-1:0]        dec_shift;
  logic [OUT_EXP_W-1:0]   dec_exp;
  logic                   dec_huge;
  logic [SIG_W:0]         rnd_val;
  logic                   rnd_up;
  logic                   pk_ovf;
  logic [OUT_W-1:0]       pk_half;

  sp2hp_decode #(
    .IN_EXP_W(IN_EXP_W), .IN_MAN_W(IN_MAN_W),
    .OUT_EXP_W(OUT_EXP_W), .OUT_MAN_W(OUT_MAN_W), .SH_W(SH_W)
  ) u_dec (
    .in_bits(in_data), .cls(dec_cls), .sgn(dec_sgn), .sig(dec_sig),
    .shift(dec_shift), .exp_field(dec_exp), .huge(dec_huge)
  );

  sp2hp_round #(.SIG_W(SIG_W), .SH_W(SH_W)) u_rnd (
    .sig(dec_sig), .shift(dec_shift), .rounded(rnd_val), .round_up(rnd_up)
  );

  sp2hp_pack #(
    .SIG_W(SIG_W), .OUT_EXP_W(OUT_EXP_W), .OUT_MAN_W(OUT_MAN_W)
  ) u_pack (
    .cls(dec_cls), .sgn(dec_sgn), .huge(dec_huge), .exp_field(dec_exp),
    .rounded(rnd_val), .ovf(pk_ovf), .half(pk_half)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      out_data  <= '0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) out_data <= pk_half;
    end
  end

  // R9
  valid_lat_chk: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> out_valid);
  // R9
  valid_idle_chk: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> !out_valid);
  // R10
  hold_chk: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> $stable(out_data));
  // R1
  sign_chk: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> out_data[OUT_W-1] == $past(in_data[IN_W-1]));
  // R2
  nan_chk: assert property (@(posedge clk) disable iff (rst)
    (in_valid && dec_cls == NC_NAN) |=>
      out_data[OUT_W-2:0] == {{OUT_EXP_W{1'b1}}, QNAN_FRAC});
  // R4
  special_exp_chk: assert property (@(posedge clk) disable iff (rst)
    (out_valid && &out_data[OUT_W-2:OUT_MAN_W]) |->
      (out_data[OUT_MAN_W-1:0] == '0 || out_data[OUT_MAN_W-1:0] == QNAN_FRAC));
  // R7
  carry_bound_chk: assert property (@(posedge clk) disable iff (rst)
    in_valid |-> rnd_val <= RND_MAX);
  // R4
  ovf_chk: assert property (@(posedge clk) disable iff (rst)
    (in_valid && dec_cls == NC_FINITE && pk_ovf) |=>
      out_data[OUT_W-2:0] == {{OUT_EXP_W{1'b1}}, {OUT_MAN_W{1'b0}}});

endmodule

// File: tb/sim_sp2hp_conv.sv
`timescale 1ns/1ps
module sim_sp2hp_conv;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        in_valid = 1'b0;
  logic [31:0] in_data = '0;
  logic        out_valid;
  logic [15:0] out_data;

  int n_chk = 0;
  int n_bad = 0;
  int cyc = 0;

  always #4 clk = ~clk;

  sp2hp_conv u0 (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_data(in_data),
    .out_valid(out_valid), .out_data(out_data)
  );

  function automatic longint rne(input longint sig, input int sh);
    longint q, r, h;
    q = sig >> sh;
    r = sig - (q << sh);
    h = longint'(1) << (sh - 1);
    if (r > h || (r == h && q[0])) q = q + 1;
    return q;
  endfunction

  function automatic logic [15:0] ref_half(input logic [31:0] x);
    logic s;
    int e, ee, he, sh;
    longint sig, q;
    s = x[31];
    e = int'(x[30:23]);
    if (e == 255) return (x[22:0] != 0) ? {s, 15'h7E00} : {s, 15'h7C00};
    if (e == 0 && x[22:0] == 0) return {s, 15'h0};
    sig = longint'({(e != 0), x[22:0]});
    ee = (e == 0) ? 1 : e;
    he = ee - 112;
    if (he >= 1) begin
      q = rne(sig, 13);
      if (q == 2048) begin he = he + 1; q = 1024; end
      if (he >= 31) return {s, 15'h7C00};
      return {s, 5'(he), 10'(q - 1024)};
    end
    sh = 14 - he;
    q = (sh > 40) ? 0 : rne(sig, sh);
    if (q == 1024) return {s, 15'h0400};
    return {s, 5'd0, 10'(q)};
  endfunction

  function automatic string tag_of(input logic [31:0] x);
    int e;
    e = int'(x[30:23]);
    if (e == 255) return (x[22:0] != 0) ? "R2" : "R3";
    if (e >= 142) return "R4";
    if (e >= 113) return "R5";
    if (e == 0) return "R8";
    return "R6";
  endfunction

  task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic apply(input string tag, input logic [31:0] x);
    logic [15:0] e;
    e = ref_half(x);
    @(negedge clk);
    in_valid = 1'b1;
    in_data  = x;
    @(negedge clk);
    check("R9", 16'(out_valid), 16'd1);
    check(tag, out_data, e);
    check("R1", 16'(out_data[15]), 16'(x[31]));
  endtask

  initial begin
    while (cyc < 150000) begin
      @(posedge clk);
      cyc++;
    end
    n_chk++;
    n_bad++;
    $display("FAIL watchdog actual=%0d expected<150000", cyc);
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    logic [15:0] held;
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    check("R9", {out_valid, out_data[14:0]}, 16'h0);
    rst = 1'b0;
    @(negedge clk);
    check("R9", 16'(out_valid), 16'd0);

    apply("R1", 32'h3F800000);
    apply("R1", 32'hBF800000);
    apply("R2", 32'h7FC00000);
    apply("R2", 32'hFF800001);
    apply("R2", 32'h7F800001);
    apply("R3", 32'h7F800000);
    apply("R3", 32'hFF800000);
    apply("R4", 32'h477FE000);
    apply("R4", 32'h477FEFFF);
    apply("R4", 32'h477FF000);
    apply("R4", 32'hC77FF000);
    apply("R4", 32'h7F7FFFFF);
    apply("R5", 32'h3F801000);
    apply("R5", 32'h3F803000);
    apply("R5", 32'h3F801001);
    apply("R5", 32'h38800000);
    apply("R6", 32'h33800000);
    apply("R6", 32'h33000000);
    apply("R6", 32'h33000001);
    apply("R6", 32'h33C00000);
    apply("R6", 32'h387FE000);
    apply("R7", 32'h387FF000);
    apply("R7", 32'h3FFFF000);
    apply("R8", 32'h00000000);
    apply("R8", 32'h80000000);
    apply("R8", 32'h80000001);
    apply("R8", 32'h007FFFFF);

    // R10: output holds while no word is offered
    apply("R5", 32'h40490FDB);
    held = out_data;
    @(negedge clk);
    in_valid = 1'b0;
    in_data  = 32'hC0000000;
    @(negedge clk);
    check("R9", 16'(out_valid), 16'd0);
    check("R10", out_data, held);
    @(negedge clk);
    check("R10", out_data, held);

    for (int i = 0; i < 3000; i++) begin
      logic [31:0] x;
      logic [7:0]  ex;
      x = $urandom;
      ex = 8'(100 + ($urandom % 46));
      if (($urandom % 4) != 0) x[30:23] = ex;
      apply(tag_of(x), x);
    end

    @(negedge clk);
    in_valid = 1'b0;
    @(negedge clk);
    check("R9", 16'(out_valid), 16'd0);
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

endmodule